// File: doc/BRIEF.md
# Single-Bit Boolean Processor with Carry

This block carries out one-bit logic on a carry flag and on a small bank of byte-wide output latches. Each latch bit is addressed by a byte select and a bit index. A command can clear, set or invert the carry. It can clear, set or invert one latch bit. It can AND or OR a source bit, or the inverse of that bit, into the carry. It can also copy a source bit into the carry, or copy the carry into a latch bit.

Bits that are only read as a source come from the external pin vector. Commands that rewrite a latch bit start from the value held in the latch and ignore the pins. The complemented-source commands use the inverted source value and never touch the bit they read.

Simple commands finish in one clock. The AND, OR and carry-store commands take two clocks, and `ready_o` is low during the second one.

Top module: `bit_proc`

## Requirements
- R1: While reset is high and in the first cycle after it, every latch bit reads 1, the carry reads 0 and `ready_o` is 1.
- R2: Op 1 clears the carry, op 2 sets it and op 3 inverts it. The result is visible one clock after acceptance, and no latch bit changes.
- R3: Op 4 clears, op 5 sets and op 6 inverts the addressed latch bit, one clock after acceptance. The new value is based on the latch and not on the pins, no other latch bit changes, and the carry keeps its value. Starting from 5Dh, clearing bit 2 gives 59h, and inverting bits 1 and 2 gives 5Bh.
- R4: Op 7 (AND source into carry) clears the carry when the source pin bit is 0. When the source bit is 1 the carry is left unchanged. The result appears two clocks after acceptance.
- R5: Op 9 (OR source into carry) sets the carry when the source pin bit is 1. When the source bit is 0 the carry is left unchanged. The result appears two clocks after acceptance.
- R6: Op 8 and op 10 behave like op 7 and op 9, but they use the inverse of the source pin bit. No latch bit changes during these commands.
- R7: Op 11 loads the carry from the addressed pin bit, one clock after acceptance.
- R8: Op 12 writes the carry into the addressed latch bit, two clocks after acceptance. Other latch bits and the carry stay unchanged.
- R9: After a two-clock command is accepted, `ready_o` is low for exactly one cycle. A command offered while `ready_o` is low has no effect.
- R10: A bit address selects latch byte k at `latch_o[8k+7:8k]`, and within that byte it selects bit `cmd_bit_i`. The pin vector `pin_i` uses the same layout. A command is accepted on a rising edge where both `cmd_valid_i` and `ready_o` are 1.
- R11: Op codes 0, 13, 14 and 15 change neither the carry nor any latch bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_op_i | input | 4 | Operation code (see requirements) |
| cmd_byte_i | input | SEL_W (2) | Latch byte select |
| cmd_bit_i | input | 3 | Bit index within the byte |
| pin_i | input | NBYTES*8 (32) | Pin levels, read-only sources |
| ready_o | output | 1 | Command can be accepted |
| carry_o | output | 1 | Carry flag |
| latch_o | output | NBYTES*8 (32) | Output latch contents |

## Verification
The assertions check the following on every cycle:
- the reset values;
- the one-cycle length of the busy window;
- that carry-only commands leave the latches untouched;
- that a bit command changes at most one latch bit;
- the carry results of clear, set, load and AND with a zero source.

Only the bench scenarios can show some other behaviours. One is that a latch rewrite starts from the latch and not from the pins; the bench shows this by holding pins and latches at different values. Others are the exact worked byte values, and that a command offered during the busy cycle is dropped.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_CLR_C  = 4'd1,
    OP_SET_C  = 4'd2,
    OP_CPL_C  = 4'd3,
    OP_CLR_B  = 4'd4,
    OP_SET_B  = 4'd5,
    OP_CPL_B  = 4'd6,
    OP_AND_C  = 4'd7,
    OP_ANDN_C = 4'd8,
    OP_OR_C   = 4'd9,
    OP_ORN_C  = 4'd10,
    OP_LD_C   = 4'd11,
    OP_ST_C   = 4'd12
  } bp_op_e;

  typedef enum logic [2:0] {
    CF_KEEP, CF_ZERO, CF_ONE, CF_INV, CF_AND, CF_OR, CF_LOAD
  } carry_fn_e;

  typedef enum logic [2:0] {
    BF_NONE, BF_ZERO, BF_ONE, BF_INV, BF_CARRY
  } bit_fn_e;

  typedef struct packed {
    carry_fn_e cfn;
    bit_fn_e   bfn;
    logic      inv_src;
    logic      two_cyc;
  } bp_ctrl_t;

endpackage

// File: rtl/bp_decode.sv
module bp_decode
  import bp_pkg::*;
(
  input  logic [3:0] op_i,
  output bp_ctrl_t   ctrl_o
);

  always_comb begin
    ctrl_o = '{cfn: CF_KEEP, bfn: BF_NONE, inv_src: 1'b0, two_cyc: 1'b0};
    case (bp_op_e'(op_i))
      OP_CLR_C:  ctrl_o.cfn = CF_ZERO;
      OP_SET_C:  ctrl_o.cfn = CF_ONE;
      OP_CPL_C:  ctrl_o.cfn = CF_INV;
      OP_CLR_B:  ctrl_o.bfn = BF_ZERO;
      OP_SET_B:  ctrl_o.bfn = BF_ONE;
      OP_CPL_B:  ctrl_o.bfn = BF_INV;
      OP_AND_C:  begin ctrl_o.cfn = CF_AND; ctrl_o.two_cyc = 1'b1; end
      OP_ANDN_C: begin ctrl_o.cfn = CF_AND; ctrl_o.inv_src = 1'b1; ctrl_o.two_cyc = 1'b1; end
      OP_OR_C:   begin ctrl_o.cfn = CF_OR;  ctrl_o.two_cyc = 1'b1; end
      OP_ORN_C:  begin ctrl_o.cfn = CF_OR;  ctrl_o.inv_src = 1'b1; ctrl_o.two_cyc = 1'b1; end
      OP_LD_C:   ctrl_o.cfn = CF_LOAD;
      OP_ST_C:   begin ctrl_o.bfn = BF_CARRY; ctrl_o.two_cyc = 1'b1; end
      default:   ctrl_o.cfn = CF_KEEP;
    endcase
  end

endmodule

// File: rtl/bp_carry_unit.sv
module bp_carry_unit
  import bp_pkg::*;
(
  input  carry_fn_e fn_i,
  input  logic      carry_i,
  input  logic      src_i,
  output logic      carry_o
);

  always_comb begin
    case (fn_i)
      CF_ZERO: carry_o = 1'b0;
      CF_ONE:  carry_o = 1'b1;
      CF_INV:  carry_o = ~carry_i;
      CF_AND:  carry_o = carry_i & src_i;
      CF_OR:   carry_o = carry_i | src_i;
      CF_LOAD: carry_o = src_i;
      default: carry_o = carry_i;
    endcase
  end

endmodule

// File: rtl/bp_latch_file.sv
module bp_latch_file
  import bp_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8,
  localparam int SEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int BIT_W = $clog2(BYTE_W)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en_i,
  input  bit_fn_e                  fn_i,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic [BIT_W-1:0]         bit_i,
  input  logic                     carry_i,
  output logic [NBYTES*BYTE_W-1:0] latch_o
);

  logic [BYTE_W-1:0] cur_byte;
  logic              new_bit;

  // Rewrite value comes from the held latch, never from the pins.
  assign cur_byte = latch_o[sel_i*BYTE_W +: BYTE_W];

  always_comb begin
    case (fn_i)
      BF_ZERO:  new_bit = 1'b0;
      BF_ONE:   new_bit = 1'b1;
      BF_INV:   new_bit = ~cur_byte[bit_i];
      BF_CARRY: new_bit = carry_i;
      default:  new_bit = cur_byte[bit_i];
    endcase
  end

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        byte_q <= '1;
      end else if (en_i && (fn_i != BF_NONE) && (sel_i == SEL_W'(k))) begin
        byte_q[bit_i] <= new_bit;
      end
    end
    assign latch_o[k*BYTE_W +: BYTE_W] = byte_q;
  end

endmodule

// File: rtl/bit_proc.sv
module bit_proc
  import bp_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8,
  localparam int SEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int BIT_W = $clog2(BYTE_W),
  localparam int TOT_W = NBYTES * BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid_i,
  input  logic [3:0]       cmd_op_i,
  input  logic [SEL_W-1:0] cmd_byte_i,
  input  logic [BIT_W-1:0] cmd_bit_i,
  input  logic [TOT_W-1:0] pin_i,
  output logic             ready_o,
  output logic             carry_o,
  output logic [TOT_W-1:0] latch_o
);

  bp_ctrl_t          cmd_ctrl;
  logic [BYTE_W-1:0] pin_byte;
  logic              cmd_src;
  logic              issue;

  logic              pend_q;
  bp_ctrl_t          pend_ctrl_q;
  logic [SEL_W-1:0]  pend_sel_q;
  logic [BIT_W-1:0]  pend_bit_q;
  logic              pend_src_q;

  logic              ex_en;
  bp_ctrl_t          ex_ctrl;
  logic [SEL_W-1:0]  ex_sel;
  logic [BIT_W-1:0]  ex_bit;
  logic              ex_src;
  logic              carry_q;
  logic              carry_nxt;

  bp_decode u_dec (
    .op_i   (cmd_op_i),
    .ctrl_o (cmd_ctrl)
  );

  // Read-only sources come from the pins.
  assign pin_byte = pin_i[cmd_byte_i*BYTE_W +: BYTE_W];
  assign cmd_src  = pin_byte[cmd_bit_i] ^ cmd_ctrl.inv_src;
  assign issue    = cmd_valid_i & ~pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_ctrl_q <= '{cfn: CF_KEEP, bfn: BF_NONE, inv_src: 1'b0, two_cyc: 1'b0};
      pend_sel_q  <= '0;
      pend_bit_q  <= '0;
      pend_src_q  <= 1'b0;
    end else if (pend_q) begin
      pend_q <= 1'b0;
    end else if (issue && cmd_ctrl.two_cyc) begin
      pend_q      <= 1'b1;
      pend_ctrl_q <= cmd_ctrl;
      pend_sel_q  <= cmd_byte_i;
      pend_bit_q  <= cmd_bit_i;
      pend_src_q  <= cmd_src;
    end
  end

  always_comb begin
    if (pend_q) begin
      ex_en   = 1'b1;
      ex_ctrl = pend_ctrl_q;
      ex_sel  = pend_sel_q;
      ex_bit  = pend_bit_q;
      ex_src  = pend_src_q;
    end else begin
      ex_en   = issue & ~cmd_ctrl.two_cyc;
      ex_ctrl = cmd_ctrl;
      ex_sel  = cmd_byte_i;
      ex_bit  = cmd_bit_i;
      ex_src  = cmd_src;
    end
  end

  bp_carry_unit u_carry (
    .fn_i    (ex_ctrl.cfn),
    .carry_i (carry_q),
    .src_i   (ex_src),
    .carry_o (carry_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
    end else if (ex_en) begin
      carry_q <= carry_nxt;
    end
  end

  bp_latch_file #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .en_i    (ex_en),
    .fn_i    (ex_ctrl.bfn),
    .sel_i   (ex_sel),
    .bit_i   (ex_bit),
    .carry_i (carry_q),
    .latch_o (latch_o)
  );

  assign ready_o = ~pend_q;
  assign carry_o = carry_q;

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8,
  localparam int SEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int BIT_W = $clog2(BYTE_W),
  localparam int TOT_W = NBYTES * BYTE_W
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid_i,
  input logic [3:0]       cmd_op_i,
  input logic [SEL_W-1:0] cmd_byte_i,
  input logic [BIT_W-1:0] cmd_bit_i,
  input logic [TOT_W-1:0] pin_i,
  input logic             ready_o,
  input logic             carry_o,
  input logic [TOT_W-1:0] latch_o
);

  logic acc;
  logic pin_sel;
  logic [BYTE_W-1:0] pbyte;

  assign acc     = cmd_valid_i && ready_o;
  assign pbyte   = pin_i[cmd_byte_i*BYTE_W +: BYTE_W];
  assign pin_sel = pbyte[cmd_bit_i];

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (ready_o && !carry_o && (&latch_o)));

  assert_busy_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    !ready_o |=> ready_o);

  assert_set_carry_R2: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op_i == 4'd2) |=> carry_o);

  assert_clr_carry_R2: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op_i == 4'd1) |=> !carry_o);

  assert_carry_ops_keep_latch_R2: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op_i >= 4'd1 && cmd_op_i <= 4'd3) |=> $stable(latch_o));

  assert_bit_ops_single_bit_R3: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op_i >= 4'd4 && cmd_op_i <= 4'd6)
      |=> ($countones(latch_o ^ $past(latch_o)) <= 1) && $stable(carry_o));

  assert_and_zero_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op_i == 4'd7 && !pin_sel) |=> ##1 !carry_o);

  assert_inv_src_keeps_latch_R6: assert property (@(posedge clk) disable iff (rst)
    (acc && (cmd_op_i == 4'd8 || cmd_op_i == 4'd10)) |=> $stable(latch_o) ##1 $stable(latch_o));

  assert_load_carry_R7: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op_i == 4'd11) |=> (carry_o == $past(pin_sel)));

endmodule

bind bit_proc bp_checker #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .cmd_byte_i  (cmd_byte_i),
  .cmd_bit_i   (cmd_bit_i),
  .pin_i       (pin_i),
  .ready_o     (ready_o),
  .carry_o     (carry_o),
  .latch_o     (latch_o)
);

// File: tb/bit_proc_tb_top.sv
`timescale 1ns/1ps
module bit_proc_tb_top;

  localparam int NB = 4;
  localparam int TW = NB * 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          cmd_valid;
  logic [3:0]    cmd_op;
  logic [1:0]    cmd_byte;
  logic [2:0]    cmd_bit;
  logic [TW-1:0] pins;
  logic          ready;
  logic          carry;
  logic [TW-1:0] latch;

  always #2 clk = ~clk;

  bit_proc #(.NBYTES(NB), .BYTE_W(8)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid_i (cmd_valid),
    .cmd_op_i    (cmd_op),
    .cmd_byte_i  (cmd_byte),
    .cmd_bit_i   (cmd_bit),
    .pin_i       (pins),
    .ready_o     (ready),
    .carry_o     (carry),
    .latch_o     (latch)
  );

  typedef struct {
    logic          c;
    logic [TW-1:0] l;
    logic          r;
    string         tag;
  } exp_t;

  exp_t          sb_q[$];
  int            checks = 0;
  int            errors = 0;
  logic          m_c;
  logic [TW-1:0] m_l;
  bit            done = 0;

  // Monitor: compares the state after each completed command.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (carry !== e.c || latch !== e.l || ready !== e.r) begin
        errors++;
        $display("FAIL %s: got carry=%0b latch=%h ready=%0b, expected carry=%0b latch=%h ready=%0b",
                 e.tag, carry, latch, ready, e.c, e.l, e.r);
      end
    end
  end

  task automatic model(input logic [3:0] op, input int idx, input logic s);
    case (op)
      4'd1:  m_c = 1'b0;
      4'd2:  m_c = 1'b1;
      4'd3:  m_c = ~m_c;
      4'd4:  m_l[idx] = 1'b0;
      4'd5:  m_l[idx] = 1'b1;
      4'd6:  m_l[idx] = ~m_l[idx];
      4'd7:  if (!s) m_c = 1'b0;
      4'd8:  if (s)  m_c = 1'b0;
      4'd9:  if (s)  m_c = 1'b1;
      4'd10: if (!s) m_c = 1'b1;
      4'd11: m_c = s;
      4'd12: m_l[idx] = m_c;
      default: ;
    endcase
  endtask

  // Driver: issues one command and queues the expected state.
  task automatic run(input logic [3:0] op, input int sel, input int b,
                     input string tag, input bit poke);
    int   idx;
    bit   two;
    logic s;
    idx = sel * 8 + b;
    s   = pins[idx];
    two = (op >= 4'd7 && op <= 4'd10) || op == 4'd12;
    model(op, idx, s);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_byte  = 2'(sel);
    cmd_bit   = 3'(b);
    @(posedge clk);
    if (two) begin
      @(negedge clk);
      checks++;
      if (ready !== 1'b0) begin
        errors++;
        $display("FAIL R9: ready during busy got %0b expected 0", ready);
      end
      if (poke) cmd_op = 4'd3;  // offered while busy, must be dropped (R9)
      else      cmd_valid = 1'b0;
      @(posedge clk);
    end
    #1 cmd_valid = 1'b0;
    sb_q.push_back('{m_c, m_l, 1'b1, tag});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_byte = '0; cmd_bit = '0;
    pins = '0;
    m_c = 1'b0; m_l = '1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    sb_q.push_back('{1'b0, {TW{1'b1}}, 1'b1, "R1"});

    // Carry-only commands (R2)
    run(4'd2, 0, 0, "R2", 0);
    run(4'd3, 0, 0, "R2", 0);
    run(4'd3, 0, 0, "R2", 0);
    run(4'd1, 0, 0, "R2", 0);

    // Latch rewrite with pins held at 0, byte 1 built up to 5Dh (R3)
    run(4'd4, 1, 7, "R3", 0);
    run(4'd4, 1, 5, "R3", 0);
    run(4'd4, 1, 1, "R3", 0);
    run(4'd4, 1, 2, "R3", 0);   // 5D -> 59
    run(4'd5, 1, 2, "R3", 0);   // back to 5D
    run(4'd6, 1, 1, "R3", 0);
    run(4'd6, 1, 2, "R3", 0);   // 5B

    // Load carry from pins, byte 2 = A5h (R7)
    pins[23:16] = 8'hA5;
    run(4'd11, 2, 0, "R7", 0);
    run(4'd11, 2, 1, "R7", 0);

    // AND into carry (R4)
    run(4'd2, 0, 0, "R4", 0);
    run(4'd7, 2, 2, "R4", 0);   // source 1, carry stays 1
    run(4'd7, 2, 3, "R4", 1);   // source 0, carry cleared; poke ignored (R9)

    // OR into carry (R5)
    run(4'd9, 2, 1, "R5", 0);   // source 0, carry stays 0
    run(4'd9, 2, 0, "R5", 1);   // source 1, carry set

    // Complemented-source forms (R6)
    run(4'd8, 2, 0, "R6", 0);   // inverse 0 -> clear
    run(4'd10, 2, 1, "R6", 0);  // inverse 1 -> set
    run(4'd8, 2, 3, "R6", 1);   // inverse 1 -> keep

    // Store carry into latch (R8)
    run(4'd1, 0, 0, "R8", 0);
    run(4'd12, 3, 4, "R8", 0);
    run(4'd2, 0, 0, "R8", 0);
    run(4'd12, 3, 4, "R8", 1);

    // Unused op codes (R11)
    run(4'd0, 1, 1, "R11", 0);
    run(4'd13, 1, 1, "R11", 0);
    run(4'd15, 3, 4, "R11", 0);

    // Mixed traffic over the whole address space (R10)
    for (int i = 0; i < 80; i++) begin
      pins = $urandom();
      run(4'($urandom_range(0, 15)), $urandom_range(0, NB - 1),
          $urandom_range(0, 7), "R10", (i % 3) == 0);
    end

    while (sb_q.size() > 0) @(posedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule